// File: doc/BRIEF.md
# SPI Target Register Access Bridge

This block is an SPI target that works in clock mode 0 with 8-bit frames. It turns each serial transaction into one 32-bit read or write on a simple internal register bus. A transaction opens with a 24-bit address phase. That phase is always big-endian and most significant bit first, and it carries a write flag plus a word address. A write continues with 32 data bits. A read waits through a programmable number of padding bytes, and the target then shifts 32 data bits out on MISO.

Two word addresses are served locally. Word 0 is an interface control register that selects the payload byte order and bit order. Word 1 is a config/status register that holds the read padding count, a sticky flag raised when a read was launched before its data was ready, and a fixed interface identifier. All other word addresses go to the internal bus. The bus uses a request/acknowledge handshake, so its wait time can vary. SPI inputs are synchronised into the system clock domain and sampled there. Software picks the padding count to cover the worst-case internal access time at its chosen SPI clock rate.

Top module: `spi_reg_bridge`

## Requirements
- R1: The first 24 bits after chip select falls are taken MSB first. Bit 23 is the write flag (1 = write) and bits 22:0 are the word address. A read of a word address of 2 or above issues exactly one bus read with `bus_addr_o` equal to that word address, as soon as the 24th bit is sampled.
- R2: A write commits only after its 32nd data bit is sampled. It becomes exactly one bus write (or one local register update) carrying the full word. `bus_req_o` and its address, data and direction stay steady until `bus_ack_i`.
- R3: On a read, N x 8 padding bits follow the address, where N is config/status bits 3:0. The 32 data bits come after them. Each MISO bit is launched on an SCLK falling edge.
- R4: Payload order is set by control bit 0 and control bit 1. Bit 0 = 0 sends byte 0 (word bits 7:0) first, and bit 0 = 1 sends byte 3 first. Bit 1 = 0 sends each byte MSB first, and bit 1 = 1 sends each byte LSB first. The order applies to read and write data but never to the address phase.
- R5: A control write decodes bits 1:0 of the word as received. Software writes each byte as {b0,b1,0000,b1,b0}, so the write decodes the same under every current order. A control read returns that pattern for the stored bits.
- R6: The config/status register reads {8'h02, 7'b0, flag, 12'b0, pad[3:0]}.
- R7: If the SCLK falling edge that launches the first read data bit arrives before the read data is available, the flag at config/status bit 16 is set. The flag stays set until it is cleared.
- R8: A config/status write loads the padding count from bits 3:0. It clears the flag only when bit 16 of the written word is 1.
- R9: Reset sets little-endian, MSB-first order, padding 0 and a clear flag. It also drives `miso_o` and `bus_req_o` low.
- R10: Raising chip select before the 32nd data bit of a write discards the write. No bus access or local update takes place, and the next transaction starts at bit 0.
- R11: `miso_o` is low while chip select is high and during the address and padding bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples SCLK |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | SPI serial clock (mode 0) |
| cs_ni | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | Serial data from the controller |
| miso_o | output | 1 | Serial data to the controller |
| bus_req_o | output | 1 | Internal bus request, held until acknowledge |
| bus_we_o | output | 1 | Internal bus direction, 1 = write |
| bus_addr_o | output | 23 | Internal bus word address |
| bus_wdata_o | output | 32 | Internal bus write data |
| bus_rdata_i | input | 32 | Internal bus read data, valid with acknowledge |
| bus_ack_i | input | 1 | Internal bus acknowledge, one cycle |

## Verification
The bench builds the bridge with its default 4-bit padding field, 24-bit address and 32-bit data. An SCLK half period of eight system clocks leaves room for the input synchroniser delay. The bus stub's latency can be set from 1 to 60 cycles. With no padding, a 60-cycle access misses the first launch edge and raises the sticky flag. With one or more padding bytes, every latency in that range fits, so randomised reads across all four payload orders must return the written data.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  localparam int ADDR_BITS = 24;
  localparam int WADDR_W   = ADDR_BITS - 1;
  localparam int DATA_W    = 32;
  localparam int BYTE_W    = 8;
  localparam int NBYTES    = DATA_W / BYTE_W;
  localparam int PAD_W     = 4;
  localparam int PAD_MAX   = (1 << PAD_W) - 1;
  localparam int MAX_BITS  = ADDR_BITS + PAD_MAX * BYTE_W + DATA_W;
  localparam int CNT_W     = $clog2(MAX_BITS + 1);
  localparam int WR_BITS   = ADDR_BITS + DATA_W;
  localparam int IDX_W     = $clog2(DATA_W);
  localparam int BIDX_W    = $clog2(BYTE_W);
  localparam int NLOCAL    = 2;
  localparam int CFG_TF_BIT = 16;
  localparam int CFG_ID_LSB = 24;
  localparam logic [DATA_W-CFG_ID_LSB-1:0] IF_ID_SERIAL = 8'h02;

  typedef enum logic {LOC_CTRL = 1'b0, LOC_CFG = 1'b1} loc_sel_e;

  typedef struct packed {
    logic lsb_first;
    logic big_end;
  } order_t;

  // serial payload position -> word bit index
  function automatic logic [IDX_W-1:0] pay_idx(input logic [IDX_W-1:0] k, input order_t ord);
    logic [IDX_W-BIDX_W-1:0] wb;
    logic [BIDX_W-1:0]       wj;
    wb = ord.big_end ? ~k[IDX_W-1:BIDX_W] : k[IDX_W-1:BIDX_W];
    wj = ord.lsb_first ? k[BIDX_W-1:0] : ~k[BIDX_W-1:0];
    return {wb, wj};
  endfunction
endpackage

// File: rtl/bridge_sync.sv
module bridge_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/bridge_regs.sv
module bridge_regs
  import bridge_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  loc_sel_e          sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tf_set_i,
  output order_t            ord_o,
  output logic [PAD_W-1:0]  pad_o,
  output logic              tf_o,
  output logic [DATA_W-1:0] ctrl_rd_o,
  output logic [DATA_W-1:0] cfg_rd_o
);
  order_t           ord_q;
  logic [PAD_W-1:0] pad_q;
  logic             tf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ord_q <= '0;
      pad_q <= '0;
      tf_q  <= 1'b0;
    end else begin
      if (we_i && sel_i == LOC_CTRL) begin
        ord_q.big_end   <= wdata_i[0];
        ord_q.lsb_first <= wdata_i[1];
      end
      if (we_i && sel_i == LOC_CFG) begin
        pad_q <= wdata_i[PAD_W-1:0];
        if (wdata_i[CFG_TF_BIT]) tf_q <= 1'b0;
      end
      if (tf_set_i) tf_q <= 1'b1;
    end
  end

  // bit-palindromic byte, replicated: readable under any order
  logic [BYTE_W-1:0] ctrl_byte;
  assign ctrl_byte = {ord_q.big_end, ord_q.lsb_first, {(BYTE_W-4){1'b0}},
                      ord_q.lsb_first, ord_q.big_end};
  assign ctrl_rd_o = {NBYTES{ctrl_byte}};

  always_comb begin
    cfg_rd_o                          = '0;
    cfg_rd_o[PAD_W-1:0]               = pad_q;
    cfg_rd_o[CFG_TF_BIT]              = tf_q;
    cfg_rd_o[DATA_W-1:CFG_ID_LSB]     = IF_ID_SERIAL;
  end

  assign ord_o = ord_q;
  assign pad_o = pad_q;
  assign tf_o  = tf_q;
endmodule

// File: rtl/bridge_engine.sv
module bridge_engine
  import bridge_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_s_i,
  input  logic               cs_n_s_i,
  input  logic               mosi_s_i,
  input  order_t             ord_i,
  input  logic [PAD_W-1:0]   pad_i,
  input  logic [DATA_W-1:0]  ctrl_rd_i,
  input  logic [DATA_W-1:0]  cfg_rd_i,
  output logic               miso_o,
  output logic               bus_req_o,
  output logic               bus_we_o,
  output logic [WADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0]  bus_wdata_o,
  input  logic [DATA_W-1:0]  bus_rdata_i,
  input  logic               bus_ack_i,
  output logic               loc_we_o,
  output loc_sel_e           loc_sel_o,
  output logic [DATA_W-1:0]  loc_wdata_o,
  output logic               tf_set_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               cs_act_o
);
  localparam logic [CNT_W-1:0]   ADDR_END = CNT_W'(ADDR_BITS);
  localparam logic [CNT_W-1:0]   WR_END   = CNT_W'(WR_BITS);
  localparam logic [CNT_W-1:0]   DW_C     = CNT_W'(DATA_W);
  localparam logic [WADDR_W-1:0] LOC_LIM  = WADDR_W'(NLOCAL);

  logic                 sclk_d_q, miso_q, rd_valid_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [ADDR_BITS-1:0] addr_q;
  logic [DATA_W-1:0]    wdata_q, rdata_q;
  logic                 bus_req_q, bus_we_q;
  logic [WADDR_W-1:0]   bus_addr_q;
  logic [DATA_W-1:0]    bus_wdata_q;
  logic                 loc_we_q, tf_set_q;
  loc_sel_e             loc_sel_q;
  logic [DATA_W-1:0]    loc_wdata_q;

  logic cs_act, rise, fall;
  assign cs_act = !cs_n_s_i;
  assign rise   = cs_act && sclk_s_i && !sclk_d_q;
  assign fall   = cs_act && !sclk_s_i && sclk_d_q;

  logic [ADDR_BITS-1:0] addr_nxt;
  logic [WADDR_W-1:0]   waddr, waddr_nxt;
  logic                 is_wr;
  assign addr_nxt  = {addr_q[ADDR_BITS-2:0], mosi_s_i};
  assign waddr     = addr_q[WADDR_W-1:0];
  assign waddr_nxt = addr_nxt[WADDR_W-1:0];
  assign is_wr     = addr_q[ADDR_BITS-1];

  logic [CNT_W-1:0]  wr_off, data_start, rd_off;
  logic              in_rd_data;
  logic [DATA_W-1:0] wdata_nxt, loc_val;
  assign wr_off     = cnt_q - ADDR_END;
  assign data_start = ADDR_END + (CNT_W'(pad_i) << BIDX_W);
  assign rd_off     = cnt_q - data_start;
  assign in_rd_data = !is_wr && (cnt_q >= data_start) && (cnt_q < data_start + DW_C);
  assign loc_val    = waddr_nxt[0] ? cfg_rd_i : ctrl_rd_i;

  always_comb begin
    wdata_nxt = wdata_q;
    wdata_nxt[pay_idx(wr_off[IDX_W-1:0], ord_i)] = mosi_s_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d_q    <= 1'b0;
      cnt_q       <= '0;
      addr_q      <= '0;
      wdata_q     <= '0;
      rdata_q     <= '0;
      rd_valid_q  <= 1'b0;
      miso_q      <= 1'b0;
      bus_req_q   <= 1'b0;
      bus_we_q    <= 1'b0;
      bus_addr_q  <= '0;
      bus_wdata_q <= '0;
      loc_we_q    <= 1'b0;
      loc_sel_q   <= LOC_CTRL;
      loc_wdata_q <= '0;
      tf_set_q    <= 1'b0;
    end else begin
      sclk_d_q <= sclk_s_i;
      loc_we_q <= 1'b0;
      tf_set_q <= 1'b0;
      if (bus_req_q && bus_ack_i) begin
        bus_req_q <= 1'b0;
        if (!bus_we_q && cs_act) begin
          rdata_q    <= bus_rdata_i;
          rd_valid_q <= 1'b1;
        end
      end
      if (!cs_act) begin
        cnt_q      <= '0;
        miso_q     <= 1'b0;
        rd_valid_q <= 1'b0;
      end else begin
        if (rise) begin
          if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
          if (cnt_q < ADDR_END) addr_q <= addr_nxt;
          // address complete on a read: start the access
          if (cnt_q == ADDR_END - 1'b1 && !addr_nxt[ADDR_BITS-1]) begin
            if (waddr_nxt < LOC_LIM) begin
              rdata_q    <= loc_val;
              rd_valid_q <= 1'b1;
            end else begin
              rd_valid_q <= 1'b0;
              bus_req_q  <= 1'b1;
              bus_we_q   <= 1'b0;
              bus_addr_q <= waddr_nxt;
            end
          end
          if (is_wr && cnt_q >= ADDR_END && cnt_q < WR_END) begin
            wdata_q <= wdata_nxt;
            if (cnt_q == WR_END - 1'b1) begin
              if (waddr < LOC_LIM) begin
                loc_we_q    <= 1'b1;
                loc_sel_q   <= loc_sel_e'(waddr[0]);
                loc_wdata_q <= wdata_nxt;
              end else begin
                bus_req_q   <= 1'b1;
                bus_we_q    <= 1'b1;
                bus_addr_q  <= waddr;
                bus_wdata_q <= wdata_nxt;
              end
            end
          end
        end
        if (fall) begin
          if (in_rd_data) begin
            miso_q <= rdata_q[pay_idx(rd_off[IDX_W-1:0], ord_i)];
            if (rd_off == '0 && !rd_valid_q) tf_set_q <= 1'b1;
          end else begin
            miso_q <= 1'b0;
          end
        end
      end
    end
  end

  assign miso_o      = miso_q;
  assign bus_req_o   = bus_req_q;
  assign bus_we_o    = bus_we_q;
  assign bus_addr_o  = bus_addr_q;
  assign bus_wdata_o = bus_wdata_q;
  assign loc_we_o    = loc_we_q;
  assign loc_sel_o   = loc_sel_q;
  assign loc_wdata_o = loc_wdata_q;
  assign tf_set_o    = tf_set_q;
  assign cnt_o       = cnt_q;
  assign cs_act_o    = cs_act;
endmodule

// File: rtl/spi_reg_bridge.sv
module spi_reg_bridge
  import bridge_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               cs_ni,
  input  logic               mosi_i,
  output logic               miso_o,
  output logic               bus_req_o,
  output logic               bus_we_o,
  output logic [WADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0]  bus_wdata_o,
  input  logic [DATA_W-1:0]  bus_rdata_i,
  input  logic               bus_ack_i
);
  logic [2:0]        sync_w;
  order_t            ord_w;
  logic [PAD_W-1:0]  pad_w;
  logic              tf_w, tf_set_w, loc_we_w, cs_act_w;
  loc_sel_e          loc_sel_w;
  logic [DATA_W-1:0] loc_wdata_w, ctrl_rd_w, cfg_rd_w;
  logic [CNT_W-1:0]  cnt_w;

  bridge_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b010)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({mosi_i, cs_ni, sclk_i}),
    .q_o    (sync_w)
  );

  bridge_engine u_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_s_i    (sync_w[0]),
    .cs_n_s_i    (sync_w[1]),
    .mosi_s_i    (sync_w[2]),
    .ord_i       (ord_w),
    .pad_i       (pad_w),
    .ctrl_rd_i   (ctrl_rd_w),
    .cfg_rd_i    (cfg_rd_w),
    .miso_o      (miso_o),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_rdata_i (bus_rdata_i),
    .bus_ack_i   (bus_ack_i),
    .loc_we_o    (loc_we_w),
    .loc_sel_o   (loc_sel_w),
    .loc_wdata_o (loc_wdata_w),
    .tf_set_o    (tf_set_w),
    .cnt_o       (cnt_w),
    .cs_act_o    (cs_act_w)
  );

  bridge_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (loc_we_w),
    .sel_i     (loc_sel_w),
    .wdata_i   (loc_wdata_w),
    .tf_set_i  (tf_set_w),
    .ord_o     (ord_w),
    .pad_o     (pad_w),
    .tf_o      (tf_w),
    .ctrl_rd_o (ctrl_rd_w),
    .cfg_rd_o  (cfg_rd_w)
  );
endmodule

// File: rtl/bridge_checker.sv
module bridge_checker
  import bridge_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               miso_i,
  input logic               bus_req_i,
  input logic               bus_we_i,
  input logic [WADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0]  bus_wdata_i,
  input logic               bus_ack_i,
  input logic [CNT_W-1:0]   cnt_i,
  input logic               cs_act_i,
  input logic               loc_we_i,
  input loc_sel_e           loc_sel_i,
  input logic [DATA_W-1:0]  loc_wdata_i,
  input logic               tf_i,
  input logic               tf_set_i
);
  localparam logic [CNT_W-1:0] ADDR_END = CNT_W'(ADDR_BITS);
  localparam logic [CNT_W-1:0] WR_END   = CNT_W'(WR_BITS);

  p_req_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_i && !bus_ack_i |=> bus_req_i && $stable(bus_addr_i) &&
                                $stable(bus_we_i) && $stable(bus_wdata_i));

  p_wr_full_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_req_i) && bus_we_i |-> cnt_i == WR_END);

  p_rd_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_req_i) && !bus_we_i |-> cnt_i == ADDR_END);

  p_local_full_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_we_i |-> cnt_i == WR_END);

  p_flag_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tf_set_i |=> tf_i);

  p_flag_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tf_i && !(loc_we_i && loc_sel_i == LOC_CFG && loc_wdata_i[CFG_TF_BIT]) |=> tf_i);

  p_miso_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |=> !miso_i);
endmodule

bind spi_reg_bridge bridge_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .miso_i      (miso_o),
  .bus_req_i   (bus_req_o),
  .bus_we_i    (bus_we_o),
  .bus_addr_i  (bus_addr_o),
  .bus_wdata_i (bus_wdata_o),
  .bus_ack_i   (bus_ack_i),
  .cnt_i       (cnt_w),
  .cs_act_i    (cs_act_w),
  .loc_we_i    (loc_we_w),
  .loc_sel_i   (loc_sel_w),
  .loc_wdata_i (loc_wdata_w),
  .tf_i        (tf_w),
  .tf_set_i    (tf_set_w)
);

// File: tb/tb_spi_reg_bridge.sv
`timescale 1ns/1ps
module tb_spi_reg_bridge;
  localparam int H = 8;  // SCLK half period in clk cycles

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic        miso, bus_req, bus_we, bus_ack;
  logic [22:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  always #2.5 clk = ~clk;

  spi_reg_bridge dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata), .bus_ack_i(bus_ack)
  );

  // bus stub with programmable latency
  logic [31:0] mem [64];
  int stub_lat = 1;
  int stub_cnt;
  int wr_cnt;
  logic [22:0] last_waddr;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= '0;
      bus_ack <= 1'b0; bus_rdata <= '0; stub_cnt <= 0; wr_cnt <= 0; last_waddr <= '0;
    end else if (bus_req && !bus_ack) begin
      if (stub_cnt >= stub_lat) begin
        bus_ack   <= 1'b1;
        bus_rdata <= mem[bus_addr[5:0]];
        if (bus_we) begin
          mem[bus_addr[5:0]] <= bus_wdata;
          wr_cnt     <= wr_cnt + 1;
          last_waddr <= bus_addr;
        end
        stub_cnt <= 0;
      end else stub_cnt <= stub_cnt + 1;
    end else bus_ack <= 1'b0;
  end

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic m_be = 0, m_lsb = 0;
  int m_pad = 0;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  function automatic logic [255:0] put_addr(logic [255:0] v, logic wr, logic [22:0] a);
    logic [23:0] a24 = {wr, a};
    for (int i = 0; i < 24; i++) v[i] = a24[23-i];
    return v;
  endfunction

  function automatic logic [255:0] put_word(logic [255:0] v, int base, logic [31:0] w);
    for (int b = 0; b < 4; b++)
      for (int j = 0; j < 8; j++) begin
        int wb = m_be ? 3 - b : b;
        int wj = m_lsb ? j : 7 - j;
        v[base + 8*b + j] = w[8*wb + wj];
      end
    return v;
  endfunction

  function automatic logic [31:0] get_word(logic [255:0] v, int base);
    logic [31:0] w;
    for (int b = 0; b < 4; b++)
      for (int j = 0; j < 8; j++) begin
        int wb = m_be ? 3 - b : b;
        int wj = m_lsb ? j : 7 - j;
        w[8*wb + wj] = v[base + 8*b + j];
      end
    return w;
  endfunction

  task automatic spi_run(input int nbits, input logic [255:0] tx, output logic [255:0] rx);
    rx = '0;
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = tx[i];
      repeat (H) @(negedge clk);
      rx[i] = miso;
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (100) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [22:0] a, input logic [31:0] d, input int nbits = 56);
    logic [255:0] tx, rx;
    tx = put_word(put_addr('0, 1'b1, a), 24, d);
    spi_run(nbits, tx, rx);
  endtask

  task automatic rd_reg(input logic [22:0] a, output logic [31:0] d, output logic [255:0] rx);
    logic [255:0] tx;
    tx = put_addr('0, 1'b0, a);
    spi_run(24 + 8*m_pad + 32, tx, rx);
    d = get_word(rx, 24 + 8*m_pad);
  endtask

  task automatic set_order(input logic be, input logic lsb);
    logic [7:0] pb = {be, lsb, 4'b0000, lsb, be};
    wr_reg(23'd0, {4{pb}});
    m_be = be; m_lsb = lsb;
  endtask

  task automatic set_pad(input int p);
    wr_reg(23'd1, 32'(p));
    m_pad = p;
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    m_be = 0; m_lsb = 0; m_pad = 0; stub_lat = 1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [255:0] rx;
    int wc;
    void'($urandom(32'd1234));
    do_reset();

    // R9 reset state
    chk("R9 miso", 32'(miso), 0);
    chk("R9 bus_req", 32'(bus_req), 0);
    rd_reg(23'd0, d, rx); chk("R9 ctrl default", d, 32'h0);
    rd_reg(23'd1, d, rx); chk("R9 cfg default", d, 32'h0200_0000);
    chk("R11 miso quiet in address", rx[23:0], 32'h0);

    // R1 R2 write, default order
    wc = wr_cnt;
    wr_reg(23'd10, 32'hA5C3_1234);
    chk("R2 one bus write", 32'(wr_cnt - wc), 1);
    chk("R1 bus address", 32'(last_waddr), 32'd10);
    chk("R2 bus data", mem[10], 32'hA5C3_1234);
    rd_reg(23'd10, d, rx); chk("R3 readback", d, 32'hA5C3_1234);

    // R5 control pattern under order changes
    set_order(1'b1, 1'b1);
    rd_reg(23'd0, d, rx); chk("R5 ctrl be lsb", d, 32'hC3C3_C3C3);
    set_order(1'b0, 1'b1);
    rd_reg(23'd0, d, rx); chk("R5 ctrl lsb only", d, 32'h4242_4242);
    rd_reg(23'd10, d, rx); chk("R4 lsb-first read", d, 32'hA5C3_1234);
    set_order(1'b1, 1'b0);
    rd_reg(23'd10, d, rx); chk("R4 big-endian read", d, 32'hA5C3_1234);

    // R6 R3 padding
    set_pad(3);
    rd_reg(23'd1, d, rx); chk("R6 cfg layout", d, 32'h0200_0003);
    chk("R11 miso quiet in padding", rx[47:24], 32'h0);
    rd_reg(23'd10, d, rx); chk("R3 padded read", d, 32'hA5C3_1234);

    // R7 too-fast flag
    set_pad(0);
    stub_lat = 60;
    rd_reg(23'd10, d, rx);
    stub_lat = 1;
    rd_reg(23'd1, d, rx); chk("R7 flag set", d, 32'h0201_0000);
    set_pad(1);
    rd_reg(23'd1, d, rx); chk("R8 pad write keeps flag", d, 32'h0201_0001);
    stub_lat = 60;
    rd_reg(23'd10, d, rx); chk("R3 slow read with padding", d, 32'hA5C3_1234);
    rd_reg(23'd1, d, rx); chk("R7 flag sticky", d, 32'h0201_0001);
    wr_reg(23'd1, 32'h0001_0001);
    rd_reg(23'd1, d, rx); chk("R8 flag cleared", d, 32'h0200_0001);

    // R10 aborted writes
    wc = wr_cnt;
    wr_reg(23'd10, 32'h1111_2222, 40);
    chk("R10 no bus write", 32'(wr_cnt - wc), 0);
    rd_reg(23'd10, d, rx); chk("R10 data kept", d, 32'hA5C3_1234);
    wr_reg(23'd0, 32'hFFFF_FFFF, 55);
    rd_reg(23'd0, d, rx); chk("R10 ctrl kept", d, 32'h8181_8181);

    // random mix, R3 R4
    for (int it = 0; it < 20; it++) begin
      logic [22:0] a = 23'(2 + ($urandom % 62));
      logic [31:0] w = $urandom;
      set_order(1'($urandom), 1'($urandom));
      set_pad(1 + ($urandom % 3));
      stub_lat = 1 + ($urandom % 60);
      wr_reg(a, w);
      chk("R2 random bus data", mem[a[5:0]], w);
      rd_reg(a, d, rx);
      chk("R4 random order readback", d, w);
    end

    // R9 reset restores defaults
    do_reset();
    rd_reg(23'd1, d, rx); chk("R9 cfg after reset", d, 32'h0200_0000);
    rd_reg(23'd0, d, rx); chk("R9 ctrl after reset", d, 32'h0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule